// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit multiplication and division for an integer pipeline over several cycles. The pipeline sends it a one-cycle start request with an operation code and two operands. The unit loads the operands, runs a fixed loop of one iteration per operand bit, and then writes a pair of private result registers. On a multiply, the high register receives the upper half of the 64-bit product and the low register receives the lower half. On a divide, the low register receives the quotient and the high register receives the remainder.

Results are read later through a move port that selects either the high or the low register. While an operation is in flight, `busy` is high. A move request made in that window raises `rdStall`, and the pipeline holds the move until the unit finishes. Signed operations work on magnitudes, and the signs are applied at the end. A divisor of zero is not trapped, but it always gives the same defined result.

Top module: `mdu_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, and both `hiOut` and `loOut` read 0.
- R2: `op` = 2'b01 is an unsigned multiply. The 64-bit product of `opA` and `opB` goes to `hiOut` (bits 63:32) and `loOut` (bits 31:0).
- R3: `op` = 2'b00 is a signed two's-complement multiply. The full 64-bit signed product is split between HI and LO in the same way as R2.
- R4: `op` = 2'b11 is an unsigned divide of `opA` by `opB`. The quotient goes to LO and the remainder goes to HI.
- R5: `op` = 2'b10 is a signed divide. The quotient is truncated toward zero, so it is negated when the operand signs differ. The remainder takes the sign of the dividend.
- R6: A start accepted at clock edge E sets `busy` to 1 from E onward. At edge E+33, `busy` drops to 0, `done` is 1 for exactly one cycle, and the new HI/LO values appear.
- R7: A `start` pulse while `busy` is 1 is ignored. It does not change the running operation, its result or its completion cycle.
- R8: `hiOut` and `loOut` keep their previous values while an operation runs. They change only in the cycle in which `done` rises.
- R9: `rdData` returns HI when `rdSel` = 1 and LO when `rdSel` = 0. `rdStall` is 1 exactly when `rdReq` is 1 while `busy` is 1.
- R10: When the divisor is zero, an unsigned divide, or a signed divide with a non-negative dividend, gives quotient 0xFFFFFFFF and a remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| rdReq | input | 1 | Move-from request |
| rdSel | input | 1 | 1 selects HI, 0 selects LO |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Selected result register |
| rdStall | output | 1 | Move request must wait |
| hiOut | output | 32 | HI register contents |
| loOut | output | 32 | LO register contents |

## Verification
The assertions assume that `start` is sampled only at clock edges, and that `op`, `opA` and `opB` are valid in the cycle the request is accepted. After that cycle, the unit does not look at these inputs again. The remainder-bound property also assumes that the divisor magnitude stays fixed for the whole loop.

The stimulus drives every input on the falling edge. It holds the operands steady only for the accepted cycle. In one run it injects a stray request with different operands part-way through, to show that those inputs are ignored.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } mdu_ctl_t;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output logic     busy,
  output logic     done,
  output mdu_ctl_t ctl
);
  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITERS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e state;
  logic [CNT_W-1:0] iterCnt;
  logic doneQ;

  always_comb begin
    ctl.load   = startReq && (state == ST_IDLE);
    ctl.step   = (state == ST_RUN);
    ctl.commit = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= ctl.commit;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST_CNT) begin
            state   <= ST_FIN;
            iterCnt <= '0;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step, ctl.commit}));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && state == ST_RUN) |=> (state != ST_IDLE));
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdu_ctl_t         ctl,
  input  mdu_op_e          opIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] hiQ,
  output logic [WIDTH-1:0] loQ
);
  localparam int W2 = 2 * WIDTH;

  logic [W2-1:0]    work;
  logic [WIDTH-1:0] divisorMag;
  logic             isDiv;
  logic             negMain;
  logic             negRem;

  // operand preparation
  logic             signedOp;
  logic             signA;
  logic             signB;
  logic [WIDTH-1:0] magA;
  logic [WIDTH-1:0] magB;

  always_comb begin
    signedOp = ~opIn[0];
    signA    = signedOp & aIn[WIDTH-1];
    signB    = signedOp & bIn[WIDTH-1];
    magA     = signA ? (~aIn + 1'b1) : aIn;
    magB     = signB ? (~bIn + 1'b1) : bIn;
  end

  // one shift-add multiply iteration
  logic [WIDTH:0]  mulSum;
  logic [W2-1:0]   mulNext;

  always_comb begin
    mulSum  = {1'b0, work[W2-1:WIDTH]} + (work[0] ? {1'b0, divisorMag} : '0);
    mulNext = {mulSum, work[WIDTH-1:1]};
  end

  // one restoring divide iteration
  logic [W2-1:0]  shifted;
  logic [WIDTH:0] trialTop;
  logic [WIDTH:0] trialDiff;
  logic [W2-1:0]  divNext;

  always_comb begin
    shifted   = {work[W2-2:0], 1'b0};
    trialTop  = {work[W2-1], shifted[W2-1:WIDTH]};
    trialDiff = trialTop - {1'b0, divisorMag};
    if (trialDiff[WIDTH])
      divNext = shifted;
    else
      divNext = {trialDiff[WIDTH-1:0], shifted[WIDTH-1:1], 1'b1};
  end

  // sign correction at commit
  logic [W2-1:0]    prodFixed;
  logic [WIDTH-1:0] quotFixed;
  logic [WIDTH-1:0] remFixed;

  always_comb begin
    prodFixed = negMain ? (~work + 1'b1) : work;
    quotFixed = negMain ? (~work[WIDTH-1:0] + 1'b1) : work[WIDTH-1:0];
    remFixed  = negRem ? (~work[W2-1:WIDTH] + 1'b1) : work[W2-1:WIDTH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work       <= '0;
      divisorMag <= '0;
      isDiv      <= 1'b0;
      negMain    <= 1'b0;
      negRem     <= 1'b0;
    end else if (ctl.load) begin
      isDiv      <= opIn[1];
      negMain    <= signA ^ signB;
      negRem     <= signA;
      if (opIn[1]) begin
        work       <= {{WIDTH{1'b0}}, magA};
        divisorMag <= magB;
      end else begin
        work       <= {{WIDTH{1'b0}}, magB};
        divisorMag <= magA;
      end
    end else if (ctl.step) begin
      work <= isDiv ? divNext : mulNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (ctl.commit) begin
      if (isDiv) begin
        hiQ <= remFixed;
        loQ <= quotFixed;
      end else begin
        hiQ <= prodFixed[W2-1:WIDTH];
        loQ <= prodFixed[WIDTH-1:0];
      end
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(hiQ) && $stable(loQ)));

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && isDiv && divisorMag != '0) |-> (work[W2-1:WIDTH] < divisorMag));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              rdReq,
  input  logic              rdSel,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStall,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] loOut
);
  mdu_ctl_t ctl;

  mdu_ctrl #(.ITERS(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (start),
    .busy     (busy),
    .done     (done),
    .ctl      (ctl)
  );

  mdu_datapath #(.WIDTH(DATA_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .opIn (mdu_op_e'(op)),
    .aIn  (opA),
    .bIn  (opB),
    .hiQ  (hiOut),
    .loQ  (loOut)
  );

  assign rdData  = rdSel ? hiOut : loOut;
  assign rdStall = rdReq & busy;

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/mdu_unit_test.sv
module mdu_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        rdReq = 1'b0;
  logic        rdSel = 1'b0;
  logic        busy, done, rdStall;
  logic [31:0] rdData, hiOut, loOut;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mdu_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .rdReq(rdReq), .rdSel(rdSel), .busy(busy), .done(done), .rdData(rdData),
    .rdStall(rdStall), .hiOut(hiOut), .loOut(loOut)
  );

  localparam int NV = 13;
  localparam logic [65:0] VECS [NV] = '{
    {2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b01, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'b00, 32'hFFFF_FFFD, 32'd5},
    {2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFF7},
    {2'b00, 32'h8000_0000, 32'h8000_0000},
    {2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {2'b11, 32'd100, 32'd7},
    {2'b11, 32'hFFFF_FFFF, 32'd10},
    {2'b11, 32'd5, 32'd9},
    {2'b10, 32'hFFFF_FF9C, 32'd7},
    {2'b10, 32'd100, 32'hFFFF_FFF9},
    {2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9},
    {2'b10, 32'h8000_0000, 32'hFFFF_FFFF}
  };

  function automatic logic [63:0] refModel(input logic [1:0] o, input logic [31:0] a,
                                           input logic [31:0] b);
    logic signed [63:0] sa, sb, sq, sr;
    logic [63:0] ua, ub;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (o)
      2'b00: refModel = sa * sb;
      2'b01: refModel = ua * ub;
      2'b10: begin
        sq = sa / sb;
        sr = sa % sb;
        refModel = {sr[31:0], sq[31:0]};
      end
      default: refModel = {(ua % ub) >> 0, 32'b0} >> 0 == 0 ? 64'b0 :
                          {ub == 0 ? 32'b0 : 32'(ua % ub), ub == 0 ? 32'b0 : 32'(ua / ub)};
    endcase
  endfunction

  function automatic string tagFor(input logic [1:0] o);
    case (o)
      2'b00: tagFor = "R3";
      2'b01: tagFor = "R2";
      2'b10: tagFor = "R5";
      default: tagFor = "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // runs one operation; returns edges from acceptance to done
  task automatic runOp(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input bit inject, output int lat);
    logic [31:0] prevHi, prevLo;
    int k;
    @(negedge clk);
    prevHi = hiOut;
    prevLo = loOut;
    start = 1'b1; op = o; opA = a; opB = b;
    @(posedge clk);
    k = 0;
    while (k < 100) begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0; opA = ~a; opB = ~b; op = ~o;
      end
      if (done) break;
      if (k == 4) begin
        // R8 results held while running
        check(hiOut == prevHi && loOut == prevLo, "R8", {hiOut, loOut}, {prevHi, prevLo});
        check(busy == 1'b1, "R6 busy", {63'b0, busy}, 64'd1);
        rdReq = 1'b1;
        #1;
        // R9 stall while busy
        check(rdStall == 1'b1, "R9 stall", {63'b0, rdStall}, 64'd1);
        rdReq = 1'b0;
      end
      if (inject && k == 2) begin
        start = 1'b1; op = 2'b01; opA = 32'hDEAD_BEEF; opB = 32'h0BAD_F00D;
      end
      if (k == 3) start = 1'b0;
      @(posedge clk);
      k++;
    end
    lat = k;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 flags", {62'b0, busy, done}, 64'd0);
    check(hiOut == 0 && loOut == 0, "R1 regs", {hiOut, loOut}, 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] vo;
      logic [31:0] va, vb;
      {vo, va, vb} = VECS[i];
      exp = refModel(vo, va, vb);
      runOp(vo, va, vb, 1'b0, lat);
      check({hiOut, loOut} == exp, tagFor(vo), {hiOut, loOut}, exp);
      check(lat == 33, "R6 latency", 64'(lat), 64'd33);
    end

    // R6 done is a single-cycle pulse
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6 pulse", {62'b0, done, busy}, 64'd0);

    // R7 stray start during run
    exp = refModel(2'b11, 32'd1000, 32'd33);
    runOp(2'b11, 32'd1000, 32'd33, 1'b1, lat);
    check({hiOut, loOut} == exp, "R7 result", {hiOut, loOut}, exp);
    check(lat == 33, "R7 latency", 64'(lat), 64'd33);
    @(negedge clk);
    check(busy == 1'b0, "R7 no restart", {63'b0, busy}, 64'd0);

    // R9 read port selection, no stall when idle
    rdReq = 1'b1; rdSel = 1'b1;
    #1;
    check(rdData == hiOut && rdStall == 1'b0, "R9 hi", {rdData, 31'b0, rdStall}, {hiOut, 32'b0});
    rdSel = 1'b0;
    #1;
    check(rdData == loOut, "R9 lo", {32'b0, rdData}, {32'b0, loOut});
    rdReq = 1'b0;

    // R10 divide by zero
    runOp(2'b11, 32'h1357_9BDF, 32'd0, 1'b0, lat);
    check({hiOut, loOut} == {32'h1357_9BDF, 32'hFFFF_FFFF}, "R10 unsigned",
          {hiOut, loOut}, {32'h1357_9BDF, 32'hFFFF_FFFF});
    runOp(2'b10, 32'd77, 32'd0, 1'b0, lat);
    check({hiOut, loOut} == {32'd77, 32'hFFFF_FFFF}, "R10 signed",
          {hiOut, loOut}, {32'd77, 32'hFFFF_FFFF});

    // R1 reset mid-operation clears state
    @(negedge clk);
    start = 1'b1; op = 2'b01; opA = 32'd3; opB = 32'd4;
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(busy == 0 && hiOut == 0 && loOut == 0, "R1 re-reset",
          {31'b0, busy, loOut}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule